// File: doc/BRIEF.md
# Trapping integer add/subtract unit

This block is the integer add/subtract stage of a fixed-length instruction pipeline. Each accepted operation takes two operands, a carry flag and a 4-bit opcode. The opcode alone selects add or subtract, whether the carry flag takes part, and the overflow policy. There are three policies: wrap around silently, trap on two's-complement overflow, or trap on unsigned overflow. No mode register enables or disables trapping.

The arithmetic is combinational. A small output stage registers the outcome, so results appear exactly one cycle after an operation is accepted with `in_valid`. That stage is a three-state machine:

- `ST_IDLE`: nothing was accepted in the previous cycle.
- `ST_WRITE`: an operation completed without a trap.
- `ST_TRAP`: an operation tripped its overflow policy.

The transitions are the same from every state. An accepted operation that overflows under its policy goes to `ST_TRAP`. Any other accepted operation goes to `ST_WRITE`. A cycle without `in_valid` goes to `ST_IDLE`. In `ST_TRAP` the destination write enable is withheld, and a one-cycle trap request with a cause code is raised. The carry/borrow output is always produced, so multi-word arithmetic can chain through the carry forms.

Top module: `trap_addsub_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `res_valid`, `res_wr_en`, `trap_req`, `res_carry`, `res_data` and `trap_cause` are all zero.
- R2: An operation accepted with `in_valid` high at a clock edge is reported with `res_valid` high for exactly the following cycle. In a cycle after an edge with `in_valid` low, `res_valid` and `trap_req` are low. In every cycle with `res_valid` high, exactly one of `res_wr_en` and `trap_req` is high.
- R3: Add forms (opcode bit 3 = 0) give `res_data` = a + b + c modulo 2^32. Here c is `in_carry` when opcode bit 2 = 1 and 0 otherwise. `res_carry` is the carry out of bit 31.
- R4: Subtract forms (opcode bit 3 = 1) give `res_data` = a - b - c modulo 2^32, with c chosen as in R3 (a borrow-in). `res_carry` is the borrow, set exactly when a < b + c as unsigned values.
- R5: Policy field opcode[1:0] = 00 (wrap) never raises `trap_req`, and always asserts `res_wr_en`, including when the operation overflows.
- R6: Policy 01 (signed trap) raises `trap_req` with `trap_cause` = 01 exactly when the signed result of R3/R4 lies outside [-2^31, 2^31-1].
- R7: Policy 10 (unsigned trap) raises `trap_req` with `trap_cause` = 10 exactly when `res_carry` (carry for add, borrow for subtract) is 1.
- R8: When `trap_req` is high, `res_wr_en` is low. `res_data` and `res_carry` still show the computed values.
- R9: `trap_req` is high only in the cycle after a trapping operation. A new trap pulse is produced for each trapping operation, including back to back. `trap_cause` is 00 whenever `trap_req` is low.
- R10: Policy 11 is reserved and behaves as wrap (never traps). On forms with opcode bit 2 = 0, `in_carry` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 4 | Opcode: [3] subtract, [2] use carry, [1:0] policy |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| in_carry | input | 1 | Carry-in (add) or borrow-in (subtract) |
| res_valid | output | 1 | Registered outcome present |
| res_data | output | WIDTH | Registered result |
| res_carry | output | 1 | Carry out (add) or borrow out (subtract) |
| res_wr_en | output | 1 | Destination write enable |
| trap_req | output | 1 | One-cycle trap request |
| trap_cause | output | 2 | 00 none, 01 signed overflow, 10 unsigned overflow |

## Verification
The bench builds the unit with its default `WIDTH` of 32. This places the signed boundaries at 0x7FFFFFFF and 0x80000000, and the unsigned boundary at 0xFFFFFFFF, so the single-step edge cases of R5 to R7 can be driven directly. The expected model works in 33-bit unsigned and 64-bit signed arithmetic. This keeps the carry, borrow and two's-complement range checks independent of the sign-bit rule in the RTL. Back-to-back trapping operations and idle gaps exercise the state transitions and the one-cycle pulse shape.

// File: rtl/trap_alu_pkg.sv
package trap_alu_pkg;

    localparam int OP_W    = 4;
    localparam int CAUSE_W = 2;

    typedef enum logic [1:0] {
        POL_WRAP = 2'b00,
        POL_SGN  = 2'b01,
        POL_UNS  = 2'b10,
        POL_RSV  = 2'b11
    } policy_e;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_SOVF = 2'b01,
        CAUSE_UOVF = 2'b10
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_WRITE = 2'b01,
        ST_TRAP  = 2'b10
    } stage_e;

    typedef struct packed {
        logic    sub;
        logic    use_cin;
        policy_e policy;
    } op_dec_t;

endpackage

// File: rtl/taf_op_decode.sv
module taf_op_decode
    import trap_alu_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output op_dec_t         dec
);

    always_comb begin
        dec.sub     = op[3];
        dec.use_cin = op[2];
        unique case (op[1:0])
            2'b01:   dec.policy = POL_SGN;
            2'b10:   dec.policy = POL_UNS;
            default: dec.policy = POL_WRAP;   // 00 and reserved 11 wrap
        endcase
    end

endmodule

// File: rtl/taf_sum_core.sv
module taf_sum_core #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    input  logic             cin,      // carry-in for add, borrow-in for subtract
    output logic [WIDTH-1:0] sum,
    output logic             cout,     // carry for add, borrow for subtract
    output logic             sgn_ovf
);

    localparam int EXT_W = WIDTH + 1;

    logic [WIDTH-1:0] b_eff;
    logic             c0;
    logic [EXT_W-1:0] wide;

    // subtract as a + ~b + ~borrow_in
    for (genvar i = 0; i < WIDTH; i++) begin : g_inv
        assign b_eff[i] = b[i] ^ sub;
    end

    assign c0   = cin ^ sub;
    assign wide = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c0};
    assign sum  = wide[WIDTH-1:0];
    assign cout = wide[WIDTH] ^ sub;

    assign sgn_ovf = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);

endmodule

// File: rtl/taf_trap_eval.sv
module taf_trap_eval
    import trap_alu_pkg::*;
(
    input  policy_e policy,
    input  logic    sgn_ovf,
    input  logic    carry,
    output logic    trap,
    output cause_e  cause
);

    always_comb begin
        trap  = 1'b0;
        cause = CAUSE_NONE;
        unique case (policy)
            POL_SGN: if (sgn_ovf) begin
                trap  = 1'b1;
                cause = CAUSE_SOVF;
            end
            POL_UNS: if (carry) begin
                trap  = 1'b1;
                cause = CAUSE_UOVF;
            end
            default: begin
                trap  = 1'b0;
                cause = CAUSE_NONE;
            end
        endcase
    end

endmodule

// File: rtl/trap_addsub_unit.sv
module trap_addsub_unit
    import trap_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [OP_W-1:0]    in_op,
    input  logic [WIDTH-1:0]   in_a,
    input  logic [WIDTH-1:0]   in_b,
    input  logic               in_carry,
    output logic               res_valid,
    output logic [WIDTH-1:0]   res_data,
    output logic               res_carry,
    output logic               res_wr_en,
    output logic               trap_req,
    output logic [CAUSE_W-1:0] trap_cause
);

    op_dec_t          dec;
    logic             cin_eff;
    logic [WIDTH-1:0] sum;
    logic             cout;
    logic             sgn_ovf;
    logic             trap_now;
    cause_e           cause_now;

    stage_e           state_q, state_d;
    logic [WIDTH-1:0] data_q;
    logic             carry_q;
    cause_e           cause_q;

    taf_op_decode u_dec (
        .op  (in_op),
        .dec (dec)
    );

    assign cin_eff = dec.use_cin & in_carry;

    taf_sum_core #(.WIDTH(WIDTH)) u_core (
        .a       (in_a),
        .b       (in_b),
        .sub     (dec.sub),
        .cin     (cin_eff),
        .sum     (sum),
        .cout    (cout),
        .sgn_ovf (sgn_ovf)
    );

    taf_trap_eval u_eval (
        .policy  (dec.policy),
        .sgn_ovf (sgn_ovf),
        .carry   (cout),
        .trap    (trap_now),
        .cause   (cause_now)
    );

    // next state: same rule from every state
    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_WRITE, ST_TRAP: begin
                if (!in_valid)     state_d = ST_IDLE;
                else if (trap_now) state_d = ST_TRAP;
                else               state_d = ST_WRITE;
            end
            default:               state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured datapath values
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            carry_q <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else if (in_valid) begin
            data_q  <= sum;
            carry_q <= cout;
            cause_q <= cause_now;
        end
    end

    // outputs decoded from the state
    always_comb begin
        res_valid  = 1'b0;
        res_wr_en  = 1'b0;
        trap_req   = 1'b0;
        trap_cause = CAUSE_NONE;
        res_data   = '0;
        res_carry  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WRITE: begin
                res_valid = 1'b1;
                res_wr_en = 1'b1;
                res_data  = data_q;
                res_carry = carry_q;
            end
            ST_TRAP: begin
                res_valid  = 1'b1;
                trap_req   = 1'b1;
                trap_cause = cause_q;
                res_data   = data_q;
                res_carry  = carry_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/taf_checker.sv
module taf_checker
    import trap_alu_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [OP_W-1:0]    in_op,
    input logic               res_valid,
    input logic               res_wr_en,
    input logic               trap_req,
    input logic [CAUSE_W-1:0] trap_cause
);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && !trap_req));

    // R2
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_wr_en != trap_req));

    // R5
    wrap_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[1:0] == 2'b00) |=> (!trap_req && res_wr_en));

    // R8
    trap_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> !res_wr_en);

    // R9
    trap_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (trap_cause != 2'b00 && trap_cause != 2'b11));

    // R9
    quiet_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |-> (trap_cause == 2'b00));

    // R10
    reserved_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[1:0] == 2'b11) |=> !trap_req);

endmodule

bind trap_addsub_unit taf_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .res_valid  (res_valid),
    .res_wr_en  (res_wr_en),
    .trap_req   (trap_req),
    .trap_cause (trap_cause)
);

// File: tb/test_trap_addsub_unit.sv
module test_trap_addsub_unit;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [3:0]   in_op = '0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         in_carry = 1'b0;
    logic         res_valid;
    logic [W-1:0] res_data;
    logic         res_carry;
    logic         res_wr_en;
    logic         trap_req;
    logic [1:0]   trap_cause;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        bit           vld;
        logic [W-1:0] res;
        bit           co;
        bit           trap;
        logic [1:0]   cause;
        string        req;
    } exp_t;

    exp_t sbq[$];

    always #5 clk = ~clk;

    trap_addsub_unit #(.WIDTH(W)) i_trap_addsub_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .in_carry(in_carry),
        .res_valid(res_valid), .res_data(res_data), .res_carry(res_carry),
        .res_wr_en(res_wr_en), .trap_req(trap_req), .trap_cause(trap_cause)
    );

    function automatic exp_t model(input logic [3:0] op, input logic [W-1:0] a,
                                   input logic [W-1:0] b, input logic cin, input string req);
        exp_t       e;
        logic [W:0] u;
        longint     sr;
        bit         sov;
        logic       c;
        c = op[2] ? cin : 1'b0;
        if (!op[3]) begin
            u  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
            sr = longint'($signed(a)) + longint'($signed(b)) + longint'(c);
        end else begin
            u  = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, c};
            sr = longint'($signed(a)) - longint'($signed(b)) - longint'(c);
        end
        sov     = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        e.vld   = 1'b1;
        e.res   = u[W-1:0];
        e.co    = u[W];
        e.trap  = 1'b0;
        e.cause = 2'b00;
        if (op[1:0] == 2'b01 && sov) begin e.trap = 1'b1; e.cause = 2'b01; end
        if (op[1:0] == 2'b10 && e.co) begin e.trap = 1'b1; e.cause = 2'b10; end
        e.req = req;
        return e;
    endfunction

    task automatic drive(input logic [3:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic cin, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_carry = cin;
        sbq.push_back(model(op, a, b, cin, req));
    endtask

    task automatic idle(input string req);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b0; in_op = 4'hF; in_a = '1; in_b = '1; in_carry = 1'b1;
        e.vld = 1'b0; e.res = '0; e.co = 1'b0; e.trap = 1'b0; e.cause = 2'b00; e.req = req;
        sbq.push_back(e);
    endtask

    // monitor: scoreboard pop, sampled 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                n_checks++;
                if (e.vld) begin
                    if (res_valid !== 1'b1 || res_data !== e.res || res_carry !== e.co ||
                        trap_req !== e.trap || trap_cause !== e.cause ||
                        res_wr_en !== !e.trap) begin
                        n_fail++;
                        $display("FAIL %s: got v=%b d=%h c=%b wr=%b t=%b cause=%b exp v=1 d=%h c=%b wr=%b t=%b cause=%b",
                                 e.req, res_valid, res_data, res_carry, res_wr_en, trap_req, trap_cause,
                                 e.res, e.co, !e.trap, e.trap, e.cause);
                    end
                end else begin
                    if (res_valid !== 1'b0 || trap_req !== 1'b0 || res_wr_en !== 1'b0) begin
                        n_fail++;
                        $display("FAIL %s: got v=%b t=%b wr=%b exp all 0", e.req, res_valid, trap_req, res_wr_en);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        lf = 32'h1234_5678;
        repeat (3) @(negedge clk);
        // R1: outputs zero during reset
        n_checks++;
        if (res_valid !== 0 || res_wr_en !== 0 || trap_req !== 0 || res_data !== 0 ||
            res_carry !== 0 || trap_cause !== 0) begin
            n_fail++;
            $display("FAIL R1: got v=%b wr=%b t=%b d=%h exp zeros", res_valid, res_wr_en, trap_req, res_data);
        end
        rst_n = 1'b1;
        idle("R1 first cycle after reset");

        // R3 add forms
        drive(4'b0000, 32'd5, 32'd7, 1'b0, "R3 add wrap");
        drive(4'b0100, 32'd5, 32'd7, 1'b1, "R3 add with carry");
        // R10 carry ignored on non-carry form
        drive(4'b0000, 32'd5, 32'd7, 1'b1, "R10 carry ignored add");
        drive(4'b1000, 32'd9, 32'd4, 1'b1, "R10 carry ignored sub");
        // R5 wrap with overflow
        drive(4'b0000, 32'hFFFF_FFFF, 32'd1, 1'b0, "R5 wrap unsigned overflow");
        drive(4'b0000, 32'h7FFF_FFFF, 32'd1, 1'b0, "R5 wrap signed overflow");
        // R6 signed trap
        drive(4'b0001, 32'h7FFF_FFFF, 32'd1, 1'b0, "R6 signed add overflow");
        drive(4'b0001, 32'hFFFF_FFFF, 32'd1, 1'b0, "R6 signed add no overflow");
        drive(4'b1001, 32'h8000_0000, 32'd1, 1'b0, "R6 signed sub overflow");
        drive(4'b0101, 32'h7FFF_FFFE, 32'd1, 1'b1, "R6 signed addc overflow by carry");
        // R7 unsigned trap
        drive(4'b0010, 32'hFFFF_FFFF, 32'd1, 1'b0, "R7 unsigned add carry");
        drive(4'b0010, 32'h7FFF_FFFF, 32'd1, 1'b0, "R7 unsigned add no carry");
        drive(4'b0110, 32'hFFFF_FFFF, 32'd0, 1'b1, "R7 unsigned addc carry");
        // R4 subtract and borrow
        drive(4'b1000, 32'd3, 32'd5, 1'b0, "R4 sub wrap borrow");
        drive(4'b1010, 32'd3, 32'd5, 1'b0, "R4 R7 sub unsigned borrow trap");
        drive(4'b1110, 32'd5, 32'd5, 1'b1, "R4 R7 subc borrow-in trap");
        drive(4'b1110, 32'd6, 32'd5, 1'b1, "R4 subc exact no borrow");
        // R10 reserved policy
        drive(4'b0011, 32'hFFFF_FFFF, 32'd1, 1'b0, "R10 reserved policy no trap");
        drive(4'b1011, 32'h8000_0000, 32'd1, 1'b0, "R10 reserved sub no trap");
        // R9 back to back traps then idle
        drive(4'b0001, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, "R9 back-to-back trap 1");
        drive(4'b0010, 32'h8000_0000, 32'h8000_0000, 1'b0, "R9 back-to-back trap 2");
        idle("R9 pulse ends");
        idle("R2 idle");
        // R8 trap keeps data visible
        drive(4'b1001, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R8 trap data visible");
        idle("R2 idle after trap");

        // mixed stream
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            ra = lf;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            rb = (lf[7:6] == 2'b00) ? ~ra : lf;
            if (lf[31:29] == 3'b000) idle("R2 random idle");
            else drive(lf[3:0], ra, rb, lf[20], "R3 R4 R6 R7 mixed");
        end
        idle("R2 tail");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule